// File: doc/BRIEF.md
# Byte-to-Word Data FIFO Engine

This block sits between a host that reads and writes 32-bit words and a card data port that moves one byte at a time. A small ring buffer of words separates the two sides. When data comes from the card, incoming bytes are gathered into words in little-endian lane order and pushed into the buffer for the host to pop. When data goes to the card, the host pushes words and the engine pops them and sends their bytes lowest lane first. A byte counter, loaded from a length register when the engine is started, falls by one for each byte moved, and the engine stops moving bytes when the counter reaches zero.

The engine publishes a status vector. Two sticky completion flags are set while the counter is zero. A group of level flags describes buffer occupancy, and only the group for the active direction is driven. Once the counter and the buffer are both empty, the engine clears its own enable bit. Each host pop sets a hold-off flag that pauses card-to-buffer movement. The hold-off lifts when the host reads status or the remaining-word count. This gives a polling host a stable buffer while it is reading it.

Top module: `bytefifo_engine`

## Requirements
- R1: After reset the control register, byte counter, remaining-word count and status vector are all zero, both card strobes are low, and the pop data output is zero.
- R2: A control write stores the 8-bit value, with bit 0 = enable and bit 1 = direction (1 = from card). When bit 0 of the written value is set, the byte counter is loaded from the 16-bit length register on the same edge.
- R3: In the from-card direction the engine takes at most one byte per cycle. Byte k of each group of four lands in word bits [8k+7:8k]. A final group of 1 to 3 bytes is pushed as a partial word with its unused upper lanes zero.
- R4: Card reads happen only while the counter is nonzero, the card ready input is high and the buffer holds fewer than 16 words. Otherwise the counter holds.
- R5: In the to-card direction each word is sent one byte per cycle, lane 0 first. Each byte sent lowers the counter by one, and sending stops at zero even when lanes of the current word are left over.
- R6: The buffer holds 16 words. A host push while it is full is dropped. A pop while it is empty changes nothing, and the pop data output reads zero whenever the buffer is empty.
- R7: A host push while the byte counter is zero is dropped.
- R8: A successful host pop sets a hold-off flag that stops card reads. A host status or count read clears it, and card reads resume in the following cycle.
- R9: Status bit 8 (data end) and bit 10 (block end) are set in every cycle in which the engine is enabled and the counter is zero. They stay set until a pulse on the clear input, which drops them unless the set condition still holds.
- R10: In the cycle after the enable bit is set with both the counter and the buffer empty, the enable bit reads zero. The direction bit is unaffected.
- R11: While enabled and not drained, the level flags for the active direction are driven. To-card uses bits 12 active, 14 at most 8 words, 16 full, 18 empty and 20 data present. From-card uses bits 13 active, 15 at least 8 words, 17 full, 19 empty and 21 data present. The flags of the other direction read zero, and all level flags read zero when disabled.
- R12: The remaining-word count output equals the byte counter divided by 4, rounded up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control value: bit 0 enable, bit 1 direction, bits 2..7 stored only |
| len_wr | input | 1 | Write strobe for the length register |
| len_wdata | input | 16 | Transfer length in bytes |
| host_push | input | 1 | Host pushes a word into the buffer |
| host_push_data | input | 32 | Word pushed by the host |
| host_pop | input | 1 | Host pops the head word |
| host_pop_data | output | 32 | Head word, zero when the buffer is empty |
| host_status_rd | input | 1 | Host reads status or word count; releases the hold-off |
| host_clr_done | input | 1 | Clears the two completion flags |
| card_rd_ready | input | 1 | Card has a byte ready to be read |
| card_rd_byte | input | 8 | Byte offered by the card |
| card_rd_strobe | output | 1 | Engine takes card_rd_byte this cycle |
| card_wr_strobe | output | 1 | Engine sends card_wr_byte this cycle |
| card_wr_byte | output | 8 | Byte sent to the card |
| ctrl_q | output | 8 | Control register contents |
| byte_count | output | 16 | Bytes remaining in the transfer |
| word_count | output | 16 | Words remaining, byte count divided by 4 rounded up |
| status | output | 22 | Completion and level flags |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a host pop and an engine push. The second pair is a host push and an engine pop. The bench provokes the first pair by draining a long from-card transfer while the card keeps streaming, so that after each hold-off release the engine refills the slot the host has just freed. It judges the result by checking every popped word against a little-endian model of the card byte stream, and by checking that the counter stalls at exactly 16 bytes left while the hold-off is held. The second pair occurs in to-card runs, where the host pushes back to back while the engine is already unpacking. Those runs are judged by comparing the captured card bytes with the pushed words, lane by lane, in order.

// File: rtl/bfe_pkg.sv
package bfe_pkg;
   localparam int CTL_EN      = 0;
   localparam int CTL_DIR     = 1;
   localparam int ST_W        = 22;
   localparam int ST_DEND     = 8;
   localparam int ST_BEND     = 10;
   localparam int ST_TX_ACT   = 12;
   localparam int ST_RX_ACT   = 13;
   localparam int ST_TX_HALF  = 14;
   localparam int ST_RX_HALF  = 15;
   localparam int ST_TX_FULL  = 16;
   localparam int ST_RX_FULL  = 17;
   localparam int ST_TX_EMPTY = 18;
   localparam int ST_RX_EMPTY = 19;
   localparam int ST_TX_AVAIL = 20;
   localparam int ST_RX_AVAIL = 21;
   localparam logic [ST_W-1:0] TX_SET = 22'h155000;
   localparam logic [ST_W-1:0] RX_SET = 22'h2AA000;
endpackage

// File: rtl/bfe_fifo.sv
module bfe_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [W-1:0]             push_data,
   input  logic                     pop,
   output logic [W-1:0]             head,
   output logic [$clog2(DEPTH):0]   occ,
   output logic                     full,
   output logic                     empty
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr;
   logic [AW-1:0] wr_ptr;
   logic          do_push;
   logic          do_pop;

   assign full    = (occ == (AW+1)'(DEPTH));
   assign empty   = (occ == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign wr_ptr  = rd_ptr + occ[AW-1:0];
   assign head    = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (do_pop) rd_ptr <= rd_ptr + AW'(1);
         occ <= occ + (AW+1)'(do_push) - (AW+1)'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end
endmodule

// File: rtl/bfe_rx_pack.sv
module bfe_rx_pack #(
   parameter int BYTE_W = 8,
   parameter int BPW    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  restart,
   input  logic                  take,
   input  logic                  last,
   input  logic [BYTE_W-1:0]     byte_in,
   output logic [BPW*BYTE_W-1:0] word_out,
   output logic                  word_valid
);
   localparam int LW = $clog2(BPW);

   logic [BPW*BYTE_W-1:0] acc;
   logic [LW-1:0]         lane;

   for (genvar g = 0; g < BPW; g++) begin : g_lane
      assign word_out[g*BYTE_W +: BYTE_W] =
         (lane == LW'(g)) ? byte_in :
         (lane >  LW'(g)) ? acc[g*BYTE_W +: BYTE_W] : '0;
   end

   assign word_valid = take && ((lane == LW'(BPW-1)) || last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         lane <= '0;
      end else if (restart || word_valid) begin
         acc  <= '0;
         lane <= '0;
      end else if (take) begin
         acc  <= word_out;
         lane <= lane + LW'(1);
      end
   end
endmodule

// File: rtl/bfe_tx_unpack.sv
module bfe_tx_unpack #(
   parameter int BYTE_W = 8,
   parameter int BPW    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  restart,
   input  logic                  send,
   input  logic [BPW*BYTE_W-1:0] head,
   output logic                  have_bytes,
   output logic [BYTE_W-1:0]     byte_out
);
   localparam int LW = $clog2(BPW);

   logic [BPW*BYTE_W-1:0] cur;
   logic [LW-1:0]         left;

   assign have_bytes = (left != '0);
   assign byte_out   = have_bytes ? cur[BYTE_W-1:0] : head[BYTE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur  <= '0;
         left <= '0;
      end else if (restart) begin
         left <= '0;
      end else if (send) begin
         if (have_bytes) begin
            cur  <= cur >> BYTE_W;
            left <= left - LW'(1);
         end else begin
            cur  <= head >> BYTE_W;
            left <= LW'(BPW-1);
         end
      end
   end
endmodule

// File: rtl/bytefifo_engine.sv
module bytefifo_engine
   import bfe_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 16,
   parameter int LEN_W  = 16,
   parameter int CTL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [CTL_W-1:0]  ctrl_wdata,
   input  logic              len_wr,
   input  logic [LEN_W-1:0]  len_wdata,
   input  logic              host_push,
   input  logic [WORD_W-1:0] host_push_data,
   input  logic              host_pop,
   output logic [WORD_W-1:0] host_pop_data,
   input  logic              host_status_rd,
   input  logic              host_clr_done,
   input  logic              card_rd_ready,
   input  logic [BYTE_W-1:0] card_rd_byte,
   output logic              card_rd_strobe,
   output logic              card_wr_strobe,
   output logic [BYTE_W-1:0] card_wr_byte,
   output logic [CTL_W-1:0]  ctrl_q,
   output logic [LEN_W-1:0]  byte_count,
   output logic [LEN_W-1:0]  word_count,
   output logic [ST_W-1:0]   status
);
   localparam int BPW   = WORD_W / BYTE_W;
   localparam int BSH   = $clog2(BPW);
   localparam int OCC_W = $clog2(DEPTH) + 1;
   localparam int HALF  = DEPTH / 2;

   if (WORD_W % BYTE_W != 0) begin : g_bad_lanes
      $error("WORD_W must be a whole number of bytes");
   end
   if (BPW < 2 || (1 << BSH) != BPW) begin : g_bad_bpw
      $error("bytes per word must be a power of two, at least 2");
   end
   if (DEPTH < 2 || (1 << (OCC_W-1)) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (CTL_W <= CTL_DIR) begin : g_bad_ctl
      $error("control register too narrow");
   end

   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  cnt;
   logic              defer_q;
   logic              dend_q;
   logic              bend_q;
   logic [OCC_W-1:0]  fifo_occ;
   logic              fifo_full;
   logic              fifo_empty;
   logic [WORD_W-1:0] fifo_head;
   logic              en;
   logic              dir_rx;
   logic              cnt_zero;
   logic              start;
   logic              host_push_ok;
   logic              host_pop_ok;
   logic              rx_move;
   logic              tx_move;
   logic              eng_pop;
   logic              have_bytes;
   logic [WORD_W-1:0] pack_word;
   logic              pack_valid;
   logic [LEN_W:0]    wc_sum;

   assign en       = ctrl_q[CTL_EN];
   assign dir_rx   = ctrl_q[CTL_DIR];
   assign cnt_zero = (cnt == '0);
   assign start    = ctrl_wr && ctrl_wdata[CTL_EN];

   assign host_push_ok = host_push && !cnt_zero && !fifo_full;
   assign host_pop_ok  = host_pop && !fifo_empty;

   assign rx_move = en && dir_rx && !cnt_zero && card_rd_ready && !defer_q
                    && !fifo_full && !host_push && !ctrl_wr;
   assign tx_move = en && !dir_rx && !cnt_zero && !ctrl_wr
                    && (have_bytes || (!fifo_empty && !host_pop));
   assign eng_pop = tx_move && !have_bytes;

   bfe_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (host_push_ok || pack_valid),
      .push_data (pack_valid ? pack_word : host_push_data),
      .pop       (host_pop_ok || eng_pop),
      .head      (fifo_head),
      .occ       (fifo_occ),
      .full      (fifo_full),
      .empty     (fifo_empty)
   );

   bfe_rx_pack #(.BYTE_W(BYTE_W), .BPW(BPW)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (start),
      .take       (rx_move),
      .last       (cnt == LEN_W'(1)),
      .byte_in    (card_rd_byte),
      .word_out   (pack_word),
      .word_valid (pack_valid)
   );

   bfe_tx_unpack #(.BYTE_W(BYTE_W), .BPW(BPW)) u_unpack (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (start),
      .send       (tx_move),
      .head       (fifo_head),
      .have_bytes (have_bytes),
      .byte_out   (card_wr_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         len_q   <= '0;
         cnt     <= '0;
         defer_q <= 1'b0;
         dend_q  <= 1'b0;
         bend_q  <= 1'b0;
      end else begin
         if (len_wr) len_q <= len_wdata;
         if (ctrl_wr) ctrl_q <= ctrl_wdata;
         else if (en && cnt_zero && fifo_empty) ctrl_q[CTL_EN] <= 1'b0;
         if (start) cnt <= len_q;
         else if (rx_move || tx_move) cnt <= cnt - LEN_W'(1);
         if (host_pop_ok) defer_q <= 1'b1;
         else if (host_status_rd) defer_q <= 1'b0;
         if (host_clr_done) begin
            dend_q <= 1'b0;
            bend_q <= 1'b0;
         end
         if (en && cnt_zero) begin
            dend_q <= 1'b1;
            bend_q <= 1'b1;
         end
      end
   end

   always_comb begin
      status = '0;
      status[ST_DEND] = dend_q;
      status[ST_BEND] = bend_q;
      if (en && !(cnt_zero && fifo_empty)) begin
         if (dir_rx) begin
            status[ST_RX_ACT]   = 1'b1;
            status[ST_RX_HALF]  = (fifo_occ >= OCC_W'(HALF));
            status[ST_RX_FULL]  = fifo_full;
            status[ST_RX_EMPTY] = fifo_empty;
            status[ST_RX_AVAIL] = !fifo_empty;
         end else begin
            status[ST_TX_ACT]   = 1'b1;
            status[ST_TX_HALF]  = (fifo_occ <= OCC_W'(HALF));
            status[ST_TX_FULL]  = fifo_full;
            status[ST_TX_EMPTY] = fifo_empty;
            status[ST_TX_AVAIL] = !fifo_empty;
         end
      end
   end

   assign wc_sum         = {1'b0, cnt} + (LEN_W+1)'(BPW-1);
   assign word_count     = LEN_W'(wc_sum >> BSH);
   assign byte_count     = cnt;
   assign host_pop_data  = fifo_head;
   assign card_rd_strobe = rx_move;
   assign card_wr_strobe = tx_move;
endmodule

// File: rtl/bytefifo_engine_chk.sv
module bytefifo_engine_chk
   import bfe_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LEN_W = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       ctrl_wr,
   input logic                       ctrl_go,
   input logic                       en_q,
   input logic                       dir_q,
   input logic                       card_rd_ready,
   input logic                       card_rd_strobe,
   input logic                       card_wr_strobe,
   input logic [LEN_W-1:0]           byte_count,
   input logic [LEN_W-1:0]           len_q,
   input logic [$clog2(DEPTH):0]     fifo_occ,
   input logic                       defer_q,
   input logic [ST_W-1:0]            status
);
   localparam int OCC_W = $clog2(DEPTH) + 1;

   assert_cnt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_go |=> byte_count == $past(len_q));

   assert_one_way_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(card_rd_strobe && card_wr_strobe));

   assert_ready_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      card_rd_strobe |-> card_rd_ready);

   assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (card_rd_strobe || card_wr_strobe) |=> byte_count == $past(byte_count) - LEN_W'(1));

   assert_stop_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_count == '0) |-> !(card_rd_strobe || card_wr_strobe));

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_occ <= OCC_W'(DEPTH));

   assert_holdoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
      defer_q |-> !card_rd_strobe);

   assert_self_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && byte_count == '0 && fifo_occ == '0 && !ctrl_wr) |=> !en_q);

   assert_dir_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & (dir_q ? TX_SET : RX_SET)) == '0));
endmodule

bind bytefifo_engine bytefifo_engine_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ctrl_wr        (ctrl_wr),
   .ctrl_go        (ctrl_wr && ctrl_wdata[bfe_pkg::CTL_EN]),
   .en_q           (ctrl_q[bfe_pkg::CTL_EN]),
   .dir_q          (ctrl_q[bfe_pkg::CTL_DIR]),
   .card_rd_ready  (card_rd_ready),
   .card_rd_strobe (card_rd_strobe),
   .card_wr_strobe (card_wr_strobe),
   .byte_count     (byte_count),
   .len_q          (len_q),
   .fifo_occ       (fifo_occ),
   .defer_q        (defer_q),
   .status         (status)
);

// File: tb/sim_bytefifo_engine.sv
module sim_bytefifo_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_wr = 1'b0;
   logic [7:0]  ctrl_wdata = '0;
   logic        len_wr = 1'b0;
   logic [15:0] len_wdata = '0;
   logic        host_push = 1'b0;
   logic [31:0] host_push_data = '0;
   logic        host_pop = 1'b0;
   logic [31:0] host_pop_data;
   logic        host_status_rd = 1'b0;
   logic        host_clr_done = 1'b0;
   logic        card_rd_ready = 1'b0;
   logic [7:0]  card_rd_byte;
   logic        card_rd_strobe;
   logic        card_wr_strobe;
   logic [7:0]  card_wr_byte;
   logic [7:0]  ctrl_q;
   logic [15:0] byte_count;
   logic [15:0] word_count;
   logic [21:0] status;

   int n_chk = 0;
   int n_bad = 0;
   int seed  = 0;
   int src_idx = 0;
   int cap_n = 0;
   logic [7:0] cap [256];
   bit finished = 1'b0;

   always #10 clk = ~clk;

   bytefifo_engine u0 (.*);

   function automatic logic [7:0] pat(input int i, input int s);
      return 8'((i * 167 + s) ^ (i >>> 3));
   endfunction

   function automatic logic [31:0] exp_word(input int base, input int w, input int len, input int s);
      logic [31:0] v = '0;
      for (int k = 0; k < 4; k++)
         if (4*w + k < len) v[8*k +: 8] = pat(base + 4*w + k, s);
      return v;
   endfunction

   assign card_rd_byte = pat(src_idx, seed);

   always @(posedge clk) begin
      if (card_rd_strobe) src_idx <= src_idx + 1;
      if (card_wr_strobe) begin
         cap[cap_n % 256] <= card_wr_byte;
         cap_n <= cap_n + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_len(input logic [15:0] v);
      @(negedge clk); len_wr = 1'b1; len_wdata = v;
      @(negedge clk); len_wr = 1'b0;
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
      @(negedge clk); ctrl_wr = 1'b0;
   endtask

   task automatic clr_done();
      @(negedge clk); host_clr_done = 1'b1;
      @(negedge clk); host_clr_done = 1'b0;
   endtask

   task automatic status_read();
      host_status_rd = 1'b1;
      @(negedge clk); host_status_rd = 1'b0;
   endtask

   // pop one word (called at a negedge), compare, then release the hold-off
   task automatic drain_word(input int base, input int w, input int len, input string tag);
      int guard = 0;
      while (!status[21] && guard < 500) begin
         @(negedge clk); guard++;
      end
      host_pop = 1'b1; #1;
      chk(tag, host_pop_data, exp_word(base, w, len, seed));
      @(negedge clk); host_pop = 1'b0;
      status_read();
   endtask

   task automatic run_rx(input int len, input string tag);
      int base;
      card_rd_ready = 1'b1;
      wr_len(16'(len));
      base = src_idx;
      wr_ctrl(8'h03);
      for (int w = 0; w < (len + 3) / 4; w++) drain_word(base, w, len, tag);
      repeat (2) @(negedge clk);
      chk({tag, " R5 count zero"}, 32'(byte_count), 32'd0);
      chk({tag, " R10 enable off"}, 32'(ctrl_q), 32'h02);
   endtask

   task automatic run_tx(input int len, input string tag);
      logic [31:0] words [16];
      int c0;
      int bad = 0;
      int nw = (len + 3) / 4;
      wr_len(16'(len));
      wr_ctrl(8'h01);
      c0 = cap_n;
      for (int i = 0; i < nw; i++) begin
         words[i] = $urandom;
         host_push = 1'b1; host_push_data = words[i];
         @(negedge clk);
      end
      host_push = 1'b0;
      repeat (len + 8) @(negedge clk);
      chk({tag, " R5 byte total"}, 32'(cap_n - c0), 32'(len));
      for (int i = 0; i < len; i++)
         if (cap[(c0 + i) % 256] !== words[i/4][8*(i%4) +: 8]) bad++;
      chk({tag, " R5 lane order mismatches"}, 32'(bad), 32'd0);
      chk({tag, " R10 enable off"}, 32'(ctrl_q), 32'h00);
   endtask

   initial begin
      int base;
      seed = int'($urandom(32'h0000_1F2E) & 32'hFF);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 ctrl", 32'(ctrl_q), 32'd0);
      chk("R1 count", 32'(byte_count), 32'd0);
      chk("R1 words", 32'(word_count), 32'd0);
      chk("R1 status", 32'(status), 32'd0);
      chk("R1 strobes", {30'd0, card_rd_strobe, card_wr_strobe}, 32'd0);
      chk("R6 empty pop data", host_pop_data, 32'd0);

      // R2 load, R4 ready gate, R11 rx flags, R12 word count
      wr_len(16'd5);
      base = src_idx;
      wr_ctrl(8'hF3);
      chk("R2 ctrl stored", 32'(ctrl_q), 32'hF3);
      chk("R2 count loaded", 32'(byte_count), 32'd5);
      chk("R12 word count of 5", 32'(word_count), 32'd2);
      chk("R11 rx flags empty", 32'(status), 32'h082000);
      repeat (4) @(negedge clk);
      chk("R4 ready low holds count", 32'(byte_count), 32'd5);
      card_rd_ready = 1'b1;
      repeat (8) @(negedge clk);
      chk("R3 five bytes taken", 32'(byte_count), 32'd0);
      chk("R9 R11 status after fill", 32'(status), 32'h202500);
      drain_word(base, 0, 5, "R3 full word");
      drain_word(base, 1, 5, "R3 partial word");
      @(negedge clk);
      chk("R10 enable cleared", 32'(ctrl_q), 32'hF2);
      chk("R9 done flags held", 32'(status), 32'h000500);
      clr_done();
      chk("R9 done flags cleared", 32'(status), 32'd0);

      // R4 full stall, R6 push to full, R8 hold-off
      wr_len(16'd80);
      base = src_idx;
      wr_ctrl(8'h03);
      repeat (90) @(negedge clk);
      chk("R4 stall at full", 32'(byte_count), 32'd16);
      chk("R12 word count of 16", 32'(word_count), 32'd4);
      chk("R11 rx full flags", 32'(status), 32'h22A000);
      host_push = 1'b1; host_push_data = 32'hDEAD_BEEF;
      @(negedge clk); host_push = 1'b0;
      host_pop = 1'b1; #1;
      chk("R6 R3 head after dropped push", host_pop_data, exp_word(base, 0, 80, seed));
      @(negedge clk); host_pop = 1'b0;
      repeat (10) @(negedge clk);
      chk("R8 hold-off stops reads", 32'(byte_count), 32'd16);
      status_read();
      repeat (10) @(negedge clk);
      chk("R8 reads resume after status read", 32'(byte_count), 32'd12);
      for (int w = 1; w < 20; w++) drain_word(base, w, 80, "R3 streamed word");
      host_pop = 1'b1; #1;
      chk("R6 pop when empty", host_pop_data, 32'd0);
      @(negedge clk); host_pop = 1'b0;
      status_read();
      @(negedge clk);
      chk("R10 enable off after stream", 32'(ctrl_q), 32'h02);
      clr_done();

      // R5 to-card, R11 tx flags
      wr_len(16'd7);
      wr_ctrl(8'h01);
      chk("R11 tx flags empty", 32'(status), 32'h045000);
      begin
         logic [31:0] a, b;
         int c0 = cap_n;
         a = $urandom; b = $urandom;
         host_push = 1'b1; host_push_data = a;
         @(negedge clk); host_push_data = b;
         @(negedge clk); host_push = 1'b0;
         repeat (12) @(negedge clk);
         chk("R5 seven bytes sent", 32'(cap_n - c0), 32'd7);
         chk("R5 first word lanes", {cap[(c0+3)%256], cap[(c0+2)%256], cap[(c0+1)%256], cap[c0%256]}, a);
         chk("R5 partial word lanes", {8'd0, cap[(c0+6)%256], cap[(c0+5)%256], cap[(c0+4)%256]}, {8'd0, b[23:0]});
      end
      chk("R5 count zero", 32'(byte_count), 32'd0);
      chk("R10 tx enable off", 32'(ctrl_q), 32'h00);
      chk("R9 tx done flags", 32'(status), 32'h000500);

      // R7 push while counter zero
      host_push = 1'b1; host_push_data = 32'h1234_5678;
      @(negedge clk); host_push = 1'b0;
      chk("R7 push dropped", host_pop_data, 32'd0);
      clr_done();

      // random mix
      for (int t = 0; t < 8; t++) begin
         int len = 1 + int'($urandom % 40);
         if ($urandom % 2 == 0) run_rx(len, "R3 random rx");
         else run_tx(len, "R5 random tx");
         clr_done();
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R1..all actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule